// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short record of finished transmissions. Each time the transmitter reports a finished frame, one status byte goes into a small store. The byte holds the outcome flags for that frame. The host reads the oldest byte at the status output. Any host write to the status location removes that byte and exposes the next one. The store has four entries. When a completion arrives while the store is full, the new byte is dropped and the overflow flag is set in the newest byte that is kept.

The block also guards the transmitter. A jabber or underrun outcome turns off the transmitter enable. An overrun of the transmit data FIFO does the same and also raises an adapter-failure level. In both cases the transmitter stays off until a transmit reset. The transmit reset empties the store, clears the failure level and turns the transmitter back on. A transmit-complete event pulse is raised for every completion that ends with an error. It is raised for a successful completion only when that completion asked for an interrupt on success.

Top module: `tx_stat_stack`

## Requirements
- R1: A stored status byte has bit 7 = 1 (complete), bit 6 = interrupt-on-success request, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow, and bits 1..0 = 0.
- R2: When the store is empty, `status_o` reads 8'h00.
- R3: `status_o` shows the oldest stored byte. A cycle with `pop_i` high removes that byte, and the change is visible after the clock edge. A pop on an empty store has no effect. With no push, pop or reset, `status_o` holds its value.
- R4: The store holds 4 bytes. A completion that arrives while the store is full and no pop occurs is dropped, and bit 2 is set in the newest retained byte.
- R5: A pop and a completion in the same cycle on a full store both take effect: the oldest byte leaves and the new byte is stored.
- R6: `tx_cmpl_o` pulses for one cycle, in the cycle after a completion is stored, when any of bits 5..3 is set or bit 6 is set. It does not pulse for a dropped completion.
- R7: An accepted completion with jabber or underrun drives `tx_en_o` low from the next cycle. It stays low until a transmit reset.
- R8: A `fifo_ovr_i` pulse sets `adapter_fail_o` and clears `tx_en_o` from the next cycle. Both hold until a transmit reset.
- R9: While `tx_en_o` is low, `done_i` is ignored: nothing is stored and no event is raised.
- R10: `tx_reset_i` empties the store, clears `adapter_fail_o` and sets `tx_en_o` from the next cycle. It overrides any completion, pop or overrun in the same cycle.
- R11: After `rst_ni` the store is empty, `tx_en_o` = 1, `adapter_fail_o` = 0 and `tx_cmpl_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | Transmission finished (one-cycle pulse) |
| ok_irq_i | input | 1 | Interrupt requested on success, qualified by `done_i` |
| jabber_i | input | 1 | Jabber outcome, qualified by `done_i` |
| underrun_i | input | 1 | Underrun outcome, qualified by `done_i` |
| max_coll_i | input | 1 | Maximum-collisions outcome, qualified by `done_i` |
| fifo_ovr_i | input | 1 | Transmit data FIFO overrun pulse |
| pop_i | input | 1 | Host write to the status location |
| tx_reset_i | input | 1 | Transmit reset command |
| status_o | output | 8 | Oldest status byte, or 0 when empty |
| tx_cmpl_o | output | 1 | Transmit-complete event pulse |
| tx_en_o | output | 1 | Transmitter enable |
| adapter_fail_o | output | 1 | Adapter failure level |

## Verification
A corrupted read or write pointer, or a wrong entry count, shows up as the wrong byte at `status_o`. This appears on the first pop after the fault or at the next fill-to-overflow, within at most five operations. A misplaced overflow mark appears only when the store wraps past full. For this reason the bench fills the store and pops every entry back out, and it checks every byte. A fault in the lock state shows at `tx_en_o` in the cycle after the fatal completion. It also shows later as completions that are stored when they should be ignored.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  typedef struct packed {
    logic       cmpl;
    logic       irq_req;
    logic       jabber;
    logic       underrun;
    logic       max_coll;
    logic       ovfl;
    logic [1:0] rsvd;
  } tx_stat_t;

  function automatic tx_stat_t make_stat(logic irq, logic jab, logic und, logic mc);
    tx_stat_t s;
    s = '0;
    s.cmpl     = 1'b1;
    s.irq_req  = irq;
    s.jabber   = jab;
    s.underrun = und;
    s.max_coll = mc;
    return s;
  endfunction

  function automatic logic wants_event(tx_stat_t s);
    return s.irq_req | s.jabber | s.underrun | s.max_coll;
  endfunction
endpackage

// File: rtl/tx_stat_store.sv
module tx_stat_store
  import tx_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_i,
  input  logic     push_i,
  input  logic     pop_i,
  input  tx_stat_t din_i,
  output tx_stat_t top_o,
  output logic     stored_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  tx_stat_t         mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, newest;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push, mark;

  function automatic logic [PTR_W-1:0] inc(logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign do_pop   = !clr_i && pop_i && (cnt_q != '0);
  assign do_push  = !clr_i && push_i && ((cnt_q != FULL) || do_pop);
  assign mark     = !clr_i && push_i && !do_push;
  assign newest   = (wr_q == '0) ? LAST : wr_q - 1'b1;
  assign stored_o = do_push;
  assign top_o    = (cnt_q == '0) ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= inc(rd_q);
      if (do_push) wr_q <= inc(wr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (do_push && wr_q == PTR_W'(i)) begin
        mem_q[i] <= din_i;
      end else if (mark && newest == PTR_W'(i)) begin
        mem_q[i].ovfl <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_lock.sv
module tx_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fatal_i,
  input  logic fifo_ovr_i,
  output logic en_o,
  output logic fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b1;
      fail_o <= 1'b0;
    end else if (clr_i) begin
      en_o   <= 1'b1;
      fail_o <= 1'b0;
    end else begin
      if (fatal_i || fifo_ovr_i) en_o <= 1'b0;
      if (fifo_ovr_i)            fail_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_cmpl_evt.sv
module tx_cmpl_evt
  import tx_stat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stored_i,
  input  tx_stat_t stat_i,
  output logic     evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= 1'b0;
    else         evt_o <= stored_i && wants_event(stat_i);
  end
endmodule

// File: rtl/tx_stat_stack.sv
module tx_stat_stack
  import tx_stat_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic       ok_irq_i,
  input  logic       jabber_i,
  input  logic       underrun_i,
  input  logic       max_coll_i,
  input  logic       fifo_ovr_i,
  input  logic       pop_i,
  input  logic       tx_reset_i,
  output logic [7:0] status_o,
  output logic       tx_cmpl_o,
  output logic       tx_en_o,
  output logic       adapter_fail_o
);
  tx_stat_t din, top;
  logic     accept, stored, fatal;

  // completions count only while the transmitter is live
  assign accept = done_i && tx_en_o && !tx_reset_i;
  assign fatal  = accept && (jabber_i || underrun_i);
  assign din    = make_stat(ok_irq_i, jabber_i, underrun_i, max_coll_i);

  tx_stat_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (tx_reset_i),
    .push_i  (accept),
    .pop_i   (pop_i),
    .din_i   (din),
    .top_o   (top),
    .stored_o(stored)
  );

  tx_lock u_lock (
    .clk_i, .rst_ni,
    .clr_i     (tx_reset_i),
    .fatal_i   (fatal),
    .fifo_ovr_i(fifo_ovr_i),
    .en_o      (tx_en_o),
    .fail_o    (adapter_fail_o)
  );

  tx_cmpl_evt u_evt (
    .clk_i, .rst_ni,
    .stored_i(stored),
    .stat_i  (din),
    .evt_o   (tx_cmpl_o)
  );

  assign status_o = top;
endmodule

// File: rtl/tx_stat_stack_chk.sv
module tx_stat_stack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_i,
  input logic       jabber_i,
  input logic       underrun_i,
  input logic       fifo_ovr_i,
  input logic       pop_i,
  input logic       tx_reset_i,
  input logic [7:0] status_o,
  input logic       tx_cmpl_o,
  input logic       tx_en_o,
  input logic       adapter_fail_o
);
  p_layout_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1:0] == 2'b00 && (status_o == 8'h00 || status_o[7]));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !pop_i && !tx_reset_i) |=> $stable(status_o));

  p_evt_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cmpl_o |-> $past(done_i) && $past(tx_en_o) && !$past(tx_reset_i));

  p_fatal_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && tx_en_o && !tx_reset_i && (jabber_i || underrun_i)) |=> !tx_en_o);

  p_lock_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_o && !tx_reset_i) |=> !tx_en_o);

  p_fifo_ovr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_ovr_i && !tx_reset_i) |=> adapter_fail_o && !tx_en_o);

  p_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_o && !tx_reset_i) |=> !tx_cmpl_o);

  p_treset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_reset_i |=> tx_en_o && !adapter_fail_o && status_o == 8'h00 && !tx_cmpl_o);
endmodule

bind tx_stat_stack tx_stat_stack_chk u_chk (
  .clk_i, .rst_ni, .done_i, .jabber_i, .underrun_i, .fifo_ovr_i, .pop_i,
  .tx_reset_i, .status_o, .tx_cmpl_o, .tx_en_o, .adapter_fail_o
);

// File: tb/sim_tx_stat_stack.sv
module sim_tx_stat_stack;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done = 0, ok_irq = 0, jab = 0, und = 0, mc = 0, ovr = 0, pop = 0, trst = 0;
  logic [7:0] status;
  logic cmpl, en, fail;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic m_en = 1'b1, m_fail = 1'b0;

  always #5 clk = ~clk;

  tx_stat_stack #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .done_i(done), .ok_irq_i(ok_irq),
    .jabber_i(jab), .underrun_i(und), .max_coll_i(mc), .fifo_ovr_i(ovr),
    .pop_i(pop), .tx_reset_i(trst), .status_o(status), .tx_cmpl_o(cmpl),
    .tx_en_o(en), .adapter_fail_o(fail)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor side: compare ports against the scoreboard after each edge
  task automatic compare(string tag, logic exp_evt);
    chk(tag, "status", status, (exp_q.size() > 0) ? exp_q[0] : 8'h00);
    chk(tag, "tx_cmpl", {7'd0, cmpl}, {7'd0, exp_evt});
    chk(tag, "tx_en", {7'd0, en}, {7'd0, m_en});
    chk(tag, "adapter_fail", {7'd0, fail}, {7'd0, m_fail});
  endtask

  // driver: fl = {irq, jabber, underrun, max_coll}
  task automatic step(logic d, logic [3:0] fl, logic p, logic o, logic r, string tag);
    logic en0, evt;
    logic [7:0] b;
    @(negedge clk);
    done = d; {ok_irq, jab, und, mc} = fl; pop = p; ovr = o; trst = r;
    @(posedge clk);
    en0 = m_en; evt = 1'b0;
    if (r) begin
      exp_q.delete(); m_en = 1'b1; m_fail = 1'b0;
    end else begin
      if (p && exp_q.size() > 0) void'(exp_q.pop_front());
      if (d && en0) begin
        b = {1'b1, fl, 3'b000};
        if (exp_q.size() < DEPTH) begin
          exp_q.push_back(b);
          evt = |fl;
        end else begin
          exp_q[exp_q.size()-1][2] = 1'b1;
        end
        if (fl[2] || fl[1]) m_en = 1'b0;
      end
      if (o) begin m_fail = 1'b1; m_en = 1'b0; end
    end
    #2;
    compare(tag, evt);
    done = 0; {ok_irq, jab, und, mc} = 4'b0; pop = 0; ovr = 0; trst = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R11", 1'b0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 4'b0000, 0, 0, 0, "R1");          // plain success 0x80, no event
    step(1, 4'b1000, 0, 0, 0, "R6");          // success with request 0xC0
    step(1, 4'b0001, 0, 0, 0, "R6");          // max collisions 0x88
    step(0, 4'b0000, 0, 0, 0, "R3");
    step(0, 4'b0000, 1, 0, 0, "R3");
    step(0, 4'b0000, 1, 0, 0, "R3");
    step(0, 4'b0000, 1, 0, 0, "R2");
    step(0, 4'b0000, 1, 0, 0, "R3");          // pop on empty

    for (int i = 0; i < DEPTH; i++) step(1, (i % 2) ? 4'b1000 : 4'b0000, 0, 0, 0, "R4");
    step(1, 4'b0001, 0, 0, 0, "R4");          // dropped, marks newest
    step(1, 4'b1000, 0, 0, 0, "R4");          // dropped again
    step(1, 4'b1001, 1, 0, 0, "R5");          // pop and push on full
    for (int i = 0; i < DEPTH + 1; i++) step(0, 4'b0000, 1, 0, 0, "R3");

    step(1, 4'b0100, 0, 0, 0, "R7");          // jabber locks
    step(1, 4'b1000, 0, 0, 0, "R9");          // ignored
    step(0, 4'b0000, 0, 0, 0, "R7");
    step(0, 4'b0000, 0, 0, 1, "R10");
    step(1, 4'b0010, 0, 0, 0, "R7");          // underrun locks
    step(1, 4'b0001, 0, 0, 0, "R9");
    step(0, 4'b0000, 1, 0, 0, "R9");
    step(0, 4'b0000, 0, 0, 1, "R10");

    step(1, 4'b0000, 0, 0, 0, "R1");
    step(0, 4'b0000, 0, 1, 0, "R8");          // FIFO overrun
    step(1, 4'b0000, 0, 0, 0, "R9");
    step(0, 4'b0000, 0, 0, 0, "R8");
    step(1, 4'b0100, 1, 1, 1, "R10");         // reset wins over all
    step(1, 4'b0011, 0, 0, 0, "R1");
    step(0, 4'b0000, 1, 0, 0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule